// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the timing strobes for a raster display. A horizontal position counter steps once per pixel clock from zero up to a programmable line total and then wraps. A vertical position counter steps each time the horizontal counter wraps, and it wraps after a programmable frame total. Each output strobe is driven from its own pair of programmable positions. The strobe turns on when the relevant counter reaches the first position and turns off when it reaches the second. The strobes are horizontal and vertical sync, horizontal and vertical blank, horizontal and vertical colour-map access windows, and horizontal and vertical pixel enable.

Software programs the block through a simple write port. A typical sequence has three steps. First, write zero to the totals register, which parks both counters at the origin. Next, load the eight strobe windows and the sync polarity. Last, write the totals, and counting begins. A freeze bit stops the raster where it is, and clearing that bit lets it continue. Because each window is a free set/clear pair, a window may start near the end of a line or frame and end after the wrap, for example a pixel-enable span that straddles the line boundary.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset (`rst_n` low) is sampled at a clock edge, the next cycle shows both positions at zero and all eight strobes low.
- R2: While running, `x_pos` steps by one each cycle up to and including the line total, then returns to 0. At that wrap `y_pos` steps by one, or returns to 0 if it had reached the frame total.
- R3: Writing 1 to bit 0 of the control register (address 0) freezes both counters and all strobes. Writing 0 to that bit lets them continue from the held values.
- R4: The totals register is address 1, with the line total in bits [11:0] and the frame total in bits [27:16]. While both fields are zero, both counters are held at 0 and the strobes keep their values.
- R5: The window register at address 3+k holds the on position in bits [11:0] and the off position in bits [27:16]. Window k is, in order, hsync, vsync, hblank, vblank, hcmap, vcmap, hpix, vpix. A running strobe goes high the cycle after its counter equals its on position and goes low the cycle after it equals its off position.
- R6: A window whose on position equals its off position never asserts.
- R7: A window whose on position is larger than its off position stays high across the counter wrap.
- R8: Odd-numbered windows (the vertical strobes) compare against `y_pos`. Even-numbered windows compare against `x_pos`.
- R9: In the polarity register (address 2), bit 0 inverts the `hsync` output and bit 1 inverts the `vsync` output.
- R10: A register write is used by the counters and comparators from the cycle after the write edge. Writes to addresses 11 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| x_pos | output | 12 | Horizontal position counter |
| y_pos | output | 12 | Vertical position counter |
| hsync | output | 1 | Horizontal sync, after polarity |
| vsync | output | 1 | Vertical sync, after polarity |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| hcmap_en | output | 1 | Horizontal colour-map access window |
| vcmap_en | output | 1 | Vertical colour-map access window |
| hpix_en | output | 1 | Horizontal pixel enable |
| vpix_en | output | 1 | Vertical pixel enable |

## Verification
The hardest situations to reach are a reprogramming event that lands mid-frame and a zero-width or wrapping window meeting the counter wrap. Both depend on exact timing between writes and counter position. The stimulus uses a tiny raster of ten pixels by six lines so that every wrap recurs within a few dozen cycles. It writes new windows, polarity, freeze and totals at arbitrary points of the raster. It also parks the counters by zeroing the totals while they are running, then restarts them with a zero line total so that the vertical counter steps every cycle. A behavioural model tracks every output on every clock.

// File: rtl/rtg_pkg.sv
// Shared constants for the raster timing generator.
// Assumes compare fields are no wider than 16 bits (two fields per word).
package rtg_pkg;
    localparam int CNT_W    = 12;
    localparam int NUM_WIN  = 8;
    localparam int HI_LSB   = 16;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL  = 4'd0,
        ADR_TOTAL = 4'd1,
        ADR_POL   = 4'd2,
        ADR_WIN0  = 4'd3
    } reg_addr_e;

    // Window indices; odd indices are vertical strobes.
    localparam int W_HSYNC  = 0;
    localparam int W_VSYNC  = 1;
    localparam int W_HBLANK = 2;
    localparam int W_VBLANK = 3;
    localparam int W_HCMAP  = 4;
    localparam int W_VCMAP  = 5;
    localparam int W_HPIX   = 6;
    localparam int W_VPIX   = 7;
endpackage

// File: rtl/rtg_regs.sv
// Register file: freeze bit, totals, sync polarity, and NW on/off window pairs.
// Assumes CW <= HI_LSB so both fields of a word fit in DW bits. Writes land at the edge.
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int NW = NUM_WIN,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    output logic                   freeze_q,
    output logic [CW-1:0]          h_total,
    output logic [CW-1:0]          v_total,
    output logic                   inv_h,
    output logic                   inv_v,
    output logic [NW-1:0][CW-1:0]  win_on,
    output logic [NW-1:0][CW-1:0]  win_off
);
    logic unused_data;
    assign unused_data = ^wr_data;

    // Control, totals and polarity registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freeze_q <= 1'b0;
            h_total  <= '0;
            v_total  <= '0;
            inv_h    <= 1'b0;
            inv_v    <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == AW'(ADR_CTRL)) begin
                freeze_q <= wr_data[0];
            end
            if (wr_addr == AW'(ADR_TOTAL)) begin
                h_total <= wr_data[CW-1:0];
                v_total <= wr_data[HI_LSB+CW-1:HI_LSB];
            end
            if (wr_addr == AW'(ADR_POL)) begin
                inv_h <= wr_data[0];
                inv_v <= wr_data[1];
            end
        end
    end

    // One on/off register pair per window, at consecutive addresses.
    for (genvar k = 0; k < NW; k++) begin : g_winreg
        localparam logic [AW-1:0] MY_ADR = AW'(int'(ADR_WIN0) + k);
        // Capture this window's compare positions on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_on[k]  <= '0;
                win_off[k] <= '0;
            end else if (wr_en && wr_addr == MY_ADR) begin
                win_on[k]  <= wr_data[CW-1:0];
                win_off[k] <= wr_data[HI_LSB+CW-1:HI_LSB];
            end
        end
    end
endmodule

// File: rtl/rtg_counters.sv
// Horizontal and vertical position counters.
// X runs 0..h_total inclusive; Y steps on X wrap and runs 0..v_total.
// Both totals zero parks the counters at the origin; freeze holds them in place.
module rtg_counters #(
    parameter int CW = rtg_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          freeze,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] v_total,
    output logic [CW-1:0] x_q,
    output logic [CW-1:0] y_q,
    output logic          held,
    output logic          run
);
    logic x_wrap;

    assign held   = (h_total == '0) && (v_total == '0);
    assign run    = !held && !freeze;
    assign x_wrap = (x_q >= h_total);

    // Advance the raster position, wrapping at each programmed total.
    always_ff @(posedge clk) begin
        if (!rst_n || held) begin
            x_q <= '0;
            y_q <= '0;
        end else if (run) begin
            if (x_wrap) begin
                x_q <= '0;
                y_q <= (y_q >= v_total) ? '0 : y_q + CW'(1);
            end else begin
                x_q <= x_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/rtg_window.sv
// One set/clear compare window. It sets on cnt == on_pos and clears on cnt == off_pos.
// Clear wins, so on == off never asserts. It updates only while the raster runs.
module rtg_window #(
    parameter int CW = rtg_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] on_pos,
    input  logic [CW-1:0] off_pos,
    output logic          win_q
);
    // Set/clear flop driven by the two equality compares.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
        end else if (run) begin
            if (cnt == off_pos) begin
                win_q <= 1'b0;
            end else if (cnt == on_pos) begin
                win_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/raster_timing_gen.sv
// Top of the raster timing generator: register file, position counters,
// and eight compare windows. Even windows follow X and odd windows follow Y.
// Sync outputs pass through the polarity flags; the other strobes are direct.
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [CW-1:0] x_pos,
    output logic [CW-1:0] y_pos,
    output logic          hsync,
    output logic          vsync,
    output logic          hblank,
    output logic          vblank,
    output logic          hcmap_en,
    output logic          vcmap_en,
    output logic          hpix_en,
    output logic          vpix_en
);
    localparam int NW = NUM_WIN;

    logic                  freeze_q;
    logic [CW-1:0]         h_total;
    logic [CW-1:0]         v_total;
    logic                  inv_h;
    logic                  inv_v;
    logic [NW-1:0][CW-1:0] win_on;
    logic [NW-1:0][CW-1:0] win_off;
    logic                  held;
    logic                  run;
    logic [NW-1:0]         win;

    rtg_regs #(.CW(CW), .NW(NW), .AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .freeze_q (freeze_q),
        .h_total  (h_total),
        .v_total  (v_total),
        .inv_h    (inv_h),
        .inv_v    (inv_v),
        .win_on   (win_on),
        .win_off  (win_off)
    );

    rtg_counters #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .freeze  (freeze_q),
        .h_total (h_total),
        .v_total (v_total),
        .x_q     (x_pos),
        .y_q     (y_pos),
        .held    (held),
        .run     (run)
    );

    for (genvar k = 0; k < NW; k++) begin : g_win
        logic [CW-1:0] sel_cnt;
        if ((k % 2) == 1) begin : g_vert
            assign sel_cnt = y_pos;
        end else begin : g_horz
            assign sel_cnt = x_pos;
        end
        rtg_window #(.CW(CW)) u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .cnt     (sel_cnt),
            .on_pos  (win_on[k]),
            .off_pos (win_off[k]),
            .win_q   (win[k])
        );
    end

    assign hsync    = win[W_HSYNC] ^ inv_h;
    assign vsync    = win[W_VSYNC] ^ inv_v;
    assign hblank   = win[W_HBLANK];
    assign vblank   = win[W_VBLANK];
    assign hcmap_en = win[W_HCMAP];
    assign vcmap_en = win[W_VCMAP];
    assign hpix_en  = win[W_HPIX];
    assign vpix_en  = win[W_VPIX];
endmodule

// File: rtl/rtg_checker.sv
// Protocol checker for raster_timing_gen, attached by bind.
// It observes the counters, run/hold state, window flops and compare registers.
module rtg_checker #(
    parameter int CW = rtg_pkg::CNT_W,
    parameter int NW = rtg_pkg::NUM_WIN
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  run,
    input logic                  held,
    input logic                  freeze_q,
    input logic [CW-1:0]         h_total,
    input logic [CW-1:0]         v_total,
    input logic [CW-1:0]         x_pos,
    input logic [CW-1:0]         y_pos,
    input logic [NW-1:0]         win,
    input logic [NW-1:0][CW-1:0] win_on,
    input logic [NW-1:0][CW-1:0] win_off
);
    // R1: reset clears positions and strobes
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (x_pos == '0 && y_pos == '0 && win == '0));

    // R2: X steps by one below the line total
    a_r2_x_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && x_pos < h_total) |=> x_pos == $past(x_pos) + CW'(1));

    // R2: X returns to zero at the line total, Y steps unless at frame total
    a_r2_x_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && x_pos >= h_total && y_pos < v_total)
        |=> (x_pos == '0 && y_pos == $past(y_pos) + CW'(1)));

    // R2: Y stays below or at the frame total once it wraps
    a_r2_y_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && x_pos >= h_total && y_pos >= v_total) |=> y_pos == '0);

    // R3: freeze holds everything
    a_r3_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_q && !held) |=> ($stable(x_pos) && $stable(y_pos) && $stable(win)));

    // R4: zero totals park counters and keep strobes
    a_r4_parked: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> (x_pos == '0 && y_pos == '0 && $stable(win)));

    for (genvar k = 0; k < NW; k++) begin : g_chk
        logic [CW-1:0] cnt_k;
        if ((k % 2) == 1) begin : g_v
            assign cnt_k = y_pos;  // R8: vertical windows follow Y
        end else begin : g_h
            assign cnt_k = x_pos;
        end
        // R5: strobe rises after its on position
        a_r5_set_at_on: assert property (@(posedge clk) disable iff (!rst_n)
            (run && cnt_k == win_on[k] && win_on[k] != win_off[k]) |=> win[k]);
        // R6: strobe is low after its off position, also when on equals off
        a_r6_clear_at_off: assert property (@(posedge clk) disable iff (!rst_n)
            (run && cnt_k == win_off[k]) |=> !win[k]);
    end
endmodule

bind raster_timing_gen rtg_checker #(.CW(CW), .NW(NW)) u_rtg_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .held     (held),
    .freeze_q (freeze_q),
    .h_total  (h_total),
    .v_total  (v_total),
    .x_pos    (x_pos),
    .y_pos    (y_pos),
    .win      (win),
    .win_on   (win_on),
    .win_off  (win_off)
);

// File: tb/raster_timing_gen_bench.sv
// Bench: behavioural reference model updated each rising edge, compared each falling edge.
module raster_timing_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] x_pos, y_pos;
    logic        hsync, vsync, hblank, vblank, hcmap_en, vcmap_en, hpix_en, vpix_en;

    raster_timing_gen u_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .x_pos(x_pos), .y_pos(y_pos), .hsync(hsync), .vsync(vsync),
        .hblank(hblank), .vblank(vblank), .hcmap_en(hcmap_en), .vcmap_en(vcmap_en),
        .hpix_en(hpix_en), .vpix_en(vpix_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;
    string tag = "R1";

    // Reference model state.
    int m_x = 0, m_y = 0, m_ht = 0, m_vt = 0, m_frz = 0, m_pol = 0;
    int m_on[8];
    int m_off[8];
    int m_w[8];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_x = 0; m_y = 0; m_ht = 0; m_vt = 0; m_frz = 0; m_pol = 0;
            for (int k = 0; k < 8; k++) begin
                m_on[k] = 0; m_off[k] = 0; m_w[k] = 0;
            end
        end else begin
            bit parked;
            bit going;
            parked = (m_ht == 0 && m_vt == 0);
            going  = !parked && (m_frz == 0);
            if (going) begin
                for (int k = 0; k < 8; k++) begin
                    int c;
                    c = (k % 2 == 1) ? m_y : m_x;
                    if (c == m_off[k]) m_w[k] = 0;
                    else if (c == m_on[k]) m_w[k] = 1;
                end
            end
            if (parked) begin
                m_x = 0; m_y = 0;
            end else if (going) begin
                if (m_x >= m_ht) begin
                    m_x = 0;
                    m_y = (m_y >= m_vt) ? 0 : m_y + 1;
                end else begin
                    m_x = m_x + 1;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    4'd0: m_frz = int'(wr_data[0]);
                    4'd1: begin
                        m_ht = int'(wr_data[11:0]);
                        m_vt = int'(wr_data[27:16]);
                    end
                    4'd2: m_pol = int'(wr_data[1:0]);
                    default: begin
                        if (wr_addr >= 4'd3 && wr_addr <= 4'd10) begin
                            m_on[int'(wr_addr) - 3]  = int'(wr_data[11:0]);
                            m_off[int'(wr_addr) - 3] = int'(wr_data[27:16]);
                        end
                    end
                endcase
            end
        end
    end

    task automatic chk(input string req, input string nm, input logic [31:0] act, input int exp);
        n_cmp++;
        if (act !== 32'(exp)) begin
            n_bad++;
            $display("FAIL %s/%s %s actual %0d expected %0d at %0t", req, tag, nm, act, exp, $time);
        end
    endtask

    // Compare every output against the model away from the rising edge.
    always @(negedge clk) begin
        if (started && !done) begin
            string rq;
            rq = rst_n ? "R2" : "R1";
            chk(rq, "x_pos", 32'(x_pos), m_x);
            chk(rq, "y_pos", 32'(y_pos), m_y);
            rq = rst_n ? "R9" : "R1";
            chk(rq, "hsync", 32'(hsync), m_w[0] ^ (m_pol & 1));
            chk(rq, "vsync", 32'(vsync), m_w[1] ^ ((m_pol >> 1) & 1));
            rq = rst_n ? "R5" : "R1";
            chk(rq, "hblank",   32'(hblank),   m_w[2]);
            chk(rq, "vblank",   32'(vblank),   m_w[3]);
            chk(rq, "hcmap_en", 32'(hcmap_en), m_w[4]);
            chk(rq, "vcmap_en", 32'(vcmap_en), m_w[5]);
            chk(rq, "hpix_en",  32'(hpix_en),  m_w[6]);
            chk(rq, "vpix_en",  32'(vpix_en),  m_w[7]);
        end
    end

    task automatic wr(input int a, input int on_v, input int off_v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(a);
        wr_data = {4'd0, 12'(off_v), 4'd0, 12'(on_v)};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        @(posedge clk);
        started = 1;
        tag = "R1";
        idle(3);
        rst_n = 1'b1;
        // R4: totals still zero, counters parked while windows load
        tag = "R4";
        wr(3, 2, 5);    // hsync
        wr(4, 1, 2);    // vsync (R8)
        wr(5, 8, 1);    // hblank wraps (R7)
        wr(6, 4, 0);    // vblank wraps (R7)
        wr(7, 3, 3);    // hcmap on == off (R6)
        wr(8, 2, 4);    // vcmap
        wr(9, 7, 3);    // hpix wraps past line end (R7)
        wr(10, 0, 4);   // vpix on at blank end line, off at blank start
        idle(10);
        tag = "R2";
        wr(1, 9, 5);
        idle(150);
        tag = "R9";
        wr(2, 3, 0);
        idle(60);
        wr(2, 1, 0);
        idle(30);
        tag = "R3";
        wr(0, 1, 0);
        idle(15);
        wr(0, 0, 0);
        idle(40);
        tag = "R10";
        wr(3, 0, 9);
        idle(30);
        wr(12, 0, 0);   // unmapped address, no effect
        wr(15, 5, 5);
        idle(30);
        tag = "R4";
        wr(1, 0, 0);
        idle(10);
        wr(1, 5, 3);
        idle(100);
        tag = "R8";
        wr(1, 0, 3);    // zero line total: Y steps each cycle
        idle(30);
        tag = "R6";
        wr(8, 1, 1);
        wr(1, 9, 5);
        idle(80);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual 0 expected 1");
            finish_run();
        end
    end
endmodule